// File: doc/BRIEF.md
# Reference Pulse Capture Monitor

This block samples a periodic reference pulse in the device-clock domain and reports how cleanly it was caught. The pulse reaches the block as a bundle of pre-sampled copies, one per delay tap. A programmable 4-bit delay code selects the tap that counts as the captured pulse. The two taps on either side of it act as guard samples.

When the selected sample goes from 0 to 1, the block raises a sticky detect flag. If either guard sample disagrees with the selected sample in that same cycle, the edge sits too close to the clock edge, and the block also raises a sticky marginal flag. Software steps the delay code across its range and reads both flags at each setting. It clears the flags between steps and picks the centre of the range that stays clean.

Access is through a small register port. Writes take effect at the clock edge, and reads are combinational.

Top module: `refpulse_capture_mon`

## Requirements
- R1: After reset, every register reads 0: control, status and delay.
- R2: The delay register (address 2) holds a 4-bit code in bits 3:0 that reads back as written. Its bits 7:4 always read 0.
- R3: Assume both enables are set and tap number `code` of `tap_in` goes from 0 in one sampled cycle to 1 in the next. The status register (address 1) then shows bit 7 (detect) as 1 two clock edges after the high sample is presented. The bit then stays at 1 until it is cleared.
- R4: A selected sample that stays high or that falls does not set the detect flag.
- R5: Status bit 6 (marginal) is set only on a detected edge. It is set when tap `code-1` or tap `code+1` differs from tap `code` in that cycle. When all three agree, it is not set.
- R6: At code 0 the lower guard is tap 0 itself, and at code 15 the upper guard is tap 15 itself.
- R7: Writing the control register (address 0) with bit 5 set clears the detect flag, and writing it with bit 4 set clears the marginal flag. Each clear affects only its own flag. Bits 5:4 of the control register always read 0.
- R8: Control bit 7 enables the receiver and control bit 6 enables processing. While either of them is 0, no flag is set.
- R9: When a clear and a new set event for the same flag fall in the same cycle, the flag ends up set.
- R10: The delay code selects which tap is judged. An edge on a tap outside the selected tap and its guards sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_in | input | 16 | Pre-sampled pulse, one bit per delay tap |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
A wrong tap index or a wrong guard clamp shows up in the status register two edges after the pulse pattern is applied. It appears as a missing detect flag or as a marginal flag that should or should not be set. Broken stickiness or clear priority becomes visible on the first status read after a clear write that collides with an edge. Faulty enable gating shows up as a flag raised on a pulse that arrives while the block is disabled.

// File: rtl/refpulse_capture_mon.sv
module refpulse_capture_mon #(
  parameter int TAPS   = 16,
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int A_CTRL = 0,
  parameter int A_STAT = 1,
  parameter int A_DLY  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] tap_in,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata
);
  localparam int SW     = $clog2(TAPS);
  localparam int B_RX   = 7;
  localparam int B_PROC = 6;
  localparam int B_CLRD = 5;
  localparam int B_CLRM = 4;
  localparam int B_DET  = 7;
  localparam int B_MARG = 6;

  logic          rx_en, proc_en, det, marg;
  logic [SW-1:0] dly, lo_idx, hi_idx;
  logic          s_c, s_l, s_h, s_p;
  logic          wr_ctrl, wr_dly, active, edge_ev, marg_ev, clr_det, clr_marg;

  assign wr_ctrl  = reg_we && (reg_addr == AW'(A_CTRL));
  assign wr_dly   = reg_we && (reg_addr == AW'(A_DLY));
  assign clr_det  = wr_ctrl && reg_wdata[B_CLRD];
  assign clr_marg = wr_ctrl && reg_wdata[B_CLRM];
  assign active   = rx_en && proc_en;

  assign lo_idx = (dly == '0) ? dly : dly - SW'(1);
  assign hi_idx = (dly == SW'(TAPS-1)) ? dly : dly + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_c <= 1'b0;
      s_l <= 1'b0;
      s_h <= 1'b0;
      s_p <= 1'b0;
    end else begin
      s_c <= tap_in[dly];
      s_l <= tap_in[lo_idx];
      s_h <= tap_in[hi_idx];
      s_p <= s_c;
    end
  end

  assign edge_ev = active && s_c && !s_p;
  assign marg_ev = edge_ev && ((s_l != s_c) || (s_h != s_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en   <= 1'b0;
      proc_en <= 1'b0;
      dly     <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_en   <= reg_wdata[B_RX];
        proc_en <= reg_wdata[B_PROC];
      end
      if (wr_dly) dly <= reg_wdata[SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det  <= 1'b0;
      marg <= 1'b0;
    end else begin
      if (edge_ev)      det <= 1'b1;
      else if (clr_det) det <= 1'b0;
      if (marg_ev)       marg <= 1'b1;
      else if (clr_marg) marg <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CTRL)) begin
      reg_rdata[B_RX]   = rx_en;
      reg_rdata[B_PROC] = proc_en;
    end else if (reg_addr == AW'(A_STAT)) begin
      reg_rdata[B_DET]  = det;
      reg_rdata[B_MARG] = marg;
    end else if (reg_addr == AW'(A_DLY)) begin
      reg_rdata[SW-1:0] = dly;
    end
  end

  // R3
  det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det && !clr_det) |=> det);
  // R5
  marg_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!marg && !edge_ev) |=> !marg);
  // R8
  no_set_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !det) |=> !det);
  // R9
  det_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> det);
  // R9
  marg_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    marg_ev |=> marg);
  // R7
  det_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_det && !edge_ev) |=> !det);
endmodule

// File: tb/refpulse_capture_mon_tb.sv
module refpulse_capture_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tap_in = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  refpulse_capture_mon dut_i (
    .clk(clk), .rst_n(rst_n), .tap_in(tap_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {code, taps before, taps after, exp detect, exp marginal}
  localparam logic [37:0] VEC [11] = '{
    {4'd5,  16'h0000, 16'h0070, 1'b1, 1'b0},  // R3 clean
    {4'd5,  16'h0000, 16'h0020, 1'b1, 1'b1},  // R5 both guards low
    {4'd5,  16'h0000, 16'h0060, 1'b1, 1'b1},  // R5 lower guard low
    {4'd5,  16'h0000, 16'h0010, 1'b0, 1'b0},  // R10 guard only
    {4'd5,  16'hFFFF, 16'hFFFF, 1'b0, 1'b0},  // R4 level high
    {4'd5,  16'hFFFF, 16'h0000, 1'b0, 1'b0},  // R4 falling
    {4'd0,  16'h0000, 16'h0003, 1'b1, 1'b0},  // R6 low end clamp
    {4'd0,  16'h0000, 16'h0001, 1'b1, 1'b1},  // R6 low end
    {4'd15, 16'h0000, 16'hC000, 1'b1, 1'b0},  // R6 high end clamp
    {4'd15, 16'h0000, 16'h8000, 1'b1, 1'b1},  // R6 high end
    {4'd9,  16'h0000, 16'h0700, 1'b1, 1'b0}   // R10 other code
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rd(4'd0, r); check("R1 ctrl", r, 8'h00);
    rd(4'd1, r); check("R1 stat", r, 8'h00);
    rd(4'd2, r); check("R1 dly", r, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd1, r); check("R1 stat after release", r, 8'h00);

    wr(4'd2, 8'hFA); rd(4'd2, r); check("R2 upper bits zero", r, 8'h0A);
    wr(4'd0, 8'hF0); rd(4'd0, r); check("R7 clear bits read zero", r, 8'hC0);

    for (int i = 0; i < 11; i++) begin
      wr(4'd2, {4'd0, VEC[i][37:34]});
      tap_in = VEC[i][33:18];
      repeat (3) @(negedge clk);
      wr(4'd0, 8'hF0);
      tap_in = VEC[i][17:2];
      repeat (3) @(negedge clk);
      rd(4'd1, r);
      check($sformatf("R3/R5 vector %0d detect", i), {7'd0, r[7]}, {7'd0, VEC[i][1]});
      check($sformatf("R5 vector %0d marginal", i), {7'd0, r[6]}, {7'd0, VEC[i][0]});
    end

    // R3 sticky after pulse drops, R7 individual clear
    wr(4'd2, 8'h05); tap_in = '0;
    repeat (3) @(negedge clk);
    wr(4'd0, 8'hF0);
    tap_in = 16'h0020; repeat (3) @(negedge clk);
    tap_in = 16'h0000; repeat (3) @(negedge clk);
    rd(4'd1, r); check("R3 sticky", r, 8'hC0);
    wr(4'd0, 8'hE0); rd(4'd1, r); check("R7 clear detect only", r, 8'h40);
    wr(4'd0, 8'hD0); rd(4'd1, r); check("R7 clear marginal", r, 8'h00);

    // R8 enables
    wr(4'd0, 8'h80); tap_in = 16'h0070; repeat (3) @(negedge clk);
    rd(4'd1, r); check("R8 processing off", r, 8'h00);
    tap_in = '0; wr(4'd0, 8'h40); tap_in = 16'h0020; repeat (3) @(negedge clk);
    rd(4'd1, r); check("R8 receiver off", r, 8'h00);
    tap_in = '0; wr(4'd0, 8'hC0); repeat (3) @(negedge clk);

    // R9 set wins over clear in same cycle
    tap_in = 16'h0020;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 8'hF0;
    @(negedge clk);
    reg_we = 1'b0;
    rd(4'd1, r); check("R9 set wins", r, 8'hC0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule